// File: doc/BRIEF.md
# Load/Store Data Width Formatter

This block sits between a 32-bit register file and a little-endian, byte-addressed data memory port. It formats data for each of four access sizes: byte, halfword, word and doubleword. On a load it takes the aligned memory words presented with the request and picks the addressed byte or halfword. It then zero-extends or sign-extends that value to 32 bits. On a store it copies a narrow value onto every byte lane of the bus and raises only the byte enables of the lanes being written. All other memory bytes keep their contents.

A doubleword transfer uses a register pair. The first register goes with the word at the base address, and the second goes with the word at base plus 4, carried on the upper-word bus. A doubleword needs only 4-byte alignment. Any access that is misaligned for its size raises a fault, and a faulting access drives no write enable and returns no load data.

The formatter only computes values. Address generation, handshakes and caching happen outside it. Each request presents its low address bits, its size, its direction and its signedness. If it is a load, the request also presents the two memory words it reads. The formatted result is registered and appears exactly one clock later.

Top module: `ldst_width_fmt`

## Requirements
- R1: An unsigned byte load (size 00, signed bit 0) returns the byte on lane k, where k is the offset and lane k is bits 8k+7..8k of the lower word. It is placed in result bits 7:0, and bits 31:8 are zero.
- R2: A signed byte load (size 00, signed bit 1) fills result bits 31:8 with copies of bit 7 of the selected byte.
- R3: A halfword load (size 01) takes bits 15:0 of the lower word at offset 0, or bits 31:16 at offset 2. It fills result bits 31:16 with zeros when the signed bit is 0, or with copies of halfword bit 15 when it is 1.
- R4: A word load (size 10) returns the lower word unchanged, whatever the signed bit is. The second result register reads zero for every size except doubleword.
- R5: A doubleword load (size 11) returns the word at the base address in the first result and the word at base plus 4 (upper memory word) in the second result. The signed bit has no effect.
- R6: A byte store copies register bits 7:0 onto all four lanes of the lower write bus and asserts exactly one lower byte enable, bit k for offset k.
- R7: A halfword store copies register bits 15:0 onto both halves of the lower write bus. Its lower byte enables are 0011 at offset 0 and 1100 at offset 2.
- R8: A word store drives the register unchanged with lower enables 1111. A doubleword store drives the first register on the lower bus and the second register on the upper bus, with both enable sets 1111. Upper enables are 0000 for every other size. For stores the signed bit has no effect.
- R9: The fault output is set for a halfword at an odd offset, and for a word or doubleword at any offset other than 0. A byte access never faults.
- R10: While fault is set, all byte enables are 0000 and all result and write data outputs are zero.
- R11: Results appear one clock after the request: the response valid output equals the request valid of the previous cycle. Reset clears every output to zero.
- R12: A load, or a cycle with no request, drives all byte enables to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 10 word, 11 double |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_byte_ofs | input | 2 | Address bits 1:0 |
| req_reg0 | input | 32 | First register of store data |
| req_reg1 | input | 32 | Second register (doubleword store) |
| mem_rd_lo | input | 32 | Memory word at the aligned base address |
| mem_rd_hi | input | 32 | Memory word at base plus 4 |
| rsp_valid | output | 1 | Formatted result present |
| rsp_fault | output | 1 | Misaligned access |
| rsp_ld0 | output | 32 | First load result register |
| rsp_ld1 | output | 32 | Second load result register |
| rsp_wdata_lo | output | 32 | Write data for the lower word |
| rsp_wdata_hi | output | 32 | Write data for the upper word |
| rsp_be_lo | output | 4 | Byte enables, lower word |
| rsp_be_hi | output | 4 | Byte enables, upper word |

## Verification
Two things can happen in the same cycle: the alignment fault, and the store-lane steering that would otherwise raise byte enables. Misaligned halfword, word and doubleword stores are issued with non-zero register data. The response must show fault together with all-zero enables and zero data. The bench also issues misaligned loads of each size against non-zero memory words, to confirm that the fault suppresses the extended result as well.

// File: rtl/ldst_width_fmt_pkg.sv
package ldst_width_fmt_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned LANES   = 4;
    localparam int unsigned WORD_W  = BYTE_W * LANES;
    localparam int unsigned OFS_W   = $clog2(LANES);
    localparam int unsigned HALF_W  = WORD_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef struct packed {
        logic              valid;
        logic              fault;
        logic [WORD_W-1:0] ld0;
        logic [WORD_W-1:0] ld1;
        logic [WORD_W-1:0] wd_lo;
        logic [WORD_W-1:0] wd_hi;
        logic [LANES-1:0]  be_lo;
        logic [LANES-1:0]  be_hi;
    } rsp_t;
endpackage

// File: rtl/ldst_align_chk.sv
module ldst_align_chk
    import ldst_width_fmt_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [OFS_W-1:0] ofs,
    output logic             misaligned
);
    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = ofs[0];
            default: misaligned = (ofs != '0);
        endcase
    end
endmodule

// File: rtl/ldst_load_sel.sv
module ldst_load_sel
    import ldst_width_fmt_pkg::*;
(
    input  logic [1:0]        size,
    input  logic              sign_ext,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] rd_lo,
    input  logic [WORD_W-1:0] rd_hi,
    output logic [WORD_W-1:0] res0,
    output logic [WORD_W-1:0] res1
);
    logic [BYTE_W-1:0] lane_byte [LANES];
    logic [BYTE_W-1:0] pick_b;
    logic [HALF_W-1:0] pick_h;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_byte[g] = rd_lo[g*BYTE_W +: BYTE_W];
    end

    assign pick_b = lane_byte[ofs];
    assign pick_h = ofs[OFS_W-1] ? rd_lo[WORD_W-1:HALF_W] : rd_lo[HALF_W-1:0];

    always_comb begin
        res1 = '0;
        unique case (size_e'(size))
            SZ_BYTE: res0 = {{(WORD_W-BYTE_W){sign_ext & pick_b[BYTE_W-1]}}, pick_b};
            SZ_HALF: res0 = {{(WORD_W-HALF_W){sign_ext & pick_h[HALF_W-1]}}, pick_h};
            SZ_WORD: res0 = rd_lo;
            default: begin
                res0 = rd_lo;
                res1 = rd_hi;
            end
        endcase
    end
endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
    import ldst_width_fmt_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [WORD_W-1:0] reg0,
    input  logic [WORD_W-1:0] reg1,
    output logic [WORD_W-1:0] wd_lo,
    output logic [WORD_W-1:0] wd_hi,
    output logic [LANES-1:0]  be_lo,
    output logic [LANES-1:0]  be_hi
);
    localparam int unsigned LANES_PER_HALF = LANES / 2;

    logic is_dbl;
    assign is_dbl = (size_e'(size) == SZ_DBL);

    for (genvar g = 0; g < LANES; g++) begin : g_be
        always_comb begin
            unique case (size_e'(size))
                SZ_BYTE: be_lo[g] = (ofs == OFS_W'(g));
                SZ_HALF: be_lo[g] = ((g / LANES_PER_HALF) == int'(ofs[OFS_W-1]));
                default: be_lo[g] = 1'b1;
            endcase
        end
        assign be_hi[g] = is_dbl;
    end

    always_comb begin
        unique case (size_e'(size))
            SZ_BYTE: wd_lo = {LANES{reg0[BYTE_W-1:0]}};
            SZ_HALF: wd_lo = {2{reg0[HALF_W-1:0]}};
            default: wd_lo = reg0;
        endcase
        wd_hi = is_dbl ? reg1 : '0;
    end
endmodule

// File: rtl/ldst_width_fmt.sv
module ldst_width_fmt
    import ldst_width_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [OFS_W-1:0]  req_byte_ofs,
    input  logic [WORD_W-1:0] req_reg0,
    input  logic [WORD_W-1:0] req_reg1,
    input  logic [WORD_W-1:0] mem_rd_lo,
    input  logic [WORD_W-1:0] mem_rd_hi,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [WORD_W-1:0] rsp_ld0,
    output logic [WORD_W-1:0] rsp_ld1,
    output logic [WORD_W-1:0] rsp_wdata_lo,
    output logic [WORD_W-1:0] rsp_wdata_hi,
    output logic [LANES-1:0]  rsp_be_lo,
    output logic [LANES-1:0]  rsp_be_hi
);
    logic              misal;
    logic [WORD_W-1:0] ld0_c, ld1_c, wlo_c, whi_c;
    logic [LANES-1:0]  belo_c, behi_c;
    rsp_t              rsp_d, rsp_q;

    ldst_align_chk u_align (
        .size       (req_size),
        .ofs        (req_byte_ofs),
        .misaligned (misal)
    );

    ldst_load_sel u_load (
        .size     (req_size),
        .sign_ext (req_signed),
        .ofs      (req_byte_ofs),
        .rd_lo    (mem_rd_lo),
        .rd_hi    (mem_rd_hi),
        .res0     (ld0_c),
        .res1     (ld1_c)
    );

    ldst_store_steer u_store (
        .size  (req_size),
        .ofs   (req_byte_ofs),
        .reg0  (req_reg0),
        .reg1  (req_reg1),
        .wd_lo (wlo_c),
        .wd_hi (whi_c),
        .be_lo (belo_c),
        .be_hi (behi_c)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.fault = misal;
            if (!misal) begin
                if (req_store) begin
                    rsp_d.wd_lo = wlo_c;
                    rsp_d.wd_hi = whi_c;
                    rsp_d.be_lo = belo_c;
                    rsp_d.be_hi = behi_c;
                end else begin
                    rsp_d.ld0 = ld0_c;
                    rsp_d.ld1 = ld1_c;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_fault    = rsp_q.fault;
    assign rsp_ld0      = rsp_q.ld0;
    assign rsp_ld1      = rsp_q.ld1;
    assign rsp_wdata_lo = rsp_q.wd_lo;
    assign rsp_wdata_hi = rsp_q.wd_hi;
    assign rsp_be_lo    = rsp_q.be_lo;
    assign rsp_be_hi    = rsp_q.be_hi;
endmodule

// File: rtl/ldst_width_fmt_chk.sv
module ldst_width_fmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic        req_signed,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_ld0,
    input logic [3:0]  rsp_be_lo,
    input logic [3:0]  rsp_be_hi
);
    // R10
    fault_blocks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> (rsp_be_lo == 4'b0) && (rsp_be_hi == 4'b0));

    // R12
    load_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid || !$past(req_store)) |-> (rsp_be_lo == 4'b0) && (rsp_be_hi == 4'b0));

    // R6
    byte_store_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_store) && ($past(req_size) == 2'd0) |-> $onehot0(rsp_be_lo) && ($countones(rsp_be_lo) == 1));

    // R1
    ubyte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !$past(req_store) && ($past(req_size) == 2'd0) && !$past(req_signed) |-> (rsp_ld0[31:8] == 24'h0));

    // R2
    sbyte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !$past(req_store) && ($past(req_size) == 2'd0) && $past(req_signed) |-> (rsp_ld0[31:8] == {24{rsp_ld0[7]}}));

    // R9
    byte_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && ($past(req_size) == 2'd0) |-> !rsp_fault);

    // R11
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
endmodule

bind ldst_width_fmt ldst_width_fmt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .req_signed (req_signed),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_ld0    (rsp_ld0),
    .rsp_be_lo  (rsp_be_lo),
    .rsp_be_hi  (rsp_be_hi)
);

// File: tb/ldst_width_fmt_tb.sv
module ldst_width_fmt_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_store, req_signed;
    logic [1:0]  req_size, req_byte_ofs;
    logic [31:0] req_reg0, req_reg1, mem_rd_lo, mem_rd_hi;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_ld0, rsp_ld1, rsp_wdata_lo, rsp_wdata_hi;
    logic [3:0]  rsp_be_lo, rsp_be_hi;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ldst_width_fmt u_dut (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive at negedge, let the posedge register it, sample 2 ns later.
    task automatic issue(logic st, logic [1:0] sz, logic sg, logic [1:0] ofs,
                         logic [31:0] r0, logic [31:0] r1,
                         logic [31:0] mlo, logic [31:0] mhi);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_size = sz; req_signed = sg;
        req_byte_ofs = ofs; req_reg0 = r0; req_reg1 = r1;
        mem_rd_lo = mlo; mem_rd_hi = mhi;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset valid", {31'b0, rsp_valid}, 32'h0);
        chk("R11 reset fault", {31'b0, rsp_fault}, 32'h0);
        chk("R11 reset ld0", rsp_ld0, 32'h0);
        chk("R11 reset be", {24'b0, rsp_be_hi, rsp_be_lo}, 32'h0);
    endtask

    task automatic t_byte_loads();
        logic [31:0] mem = 32'h8A_7F_C3_15;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] b = mem[8*k +: 8];
            issue(1'b0, 2'd0, 1'b0, 2'(k), 32'h0, 32'h0, mem, 32'hFFFF_FFFF);
            chk("R1 ubyte", rsp_ld0, {24'h0, b});
            chk("R12 load no be", {28'b0, rsp_be_lo}, 32'h0);
            issue(1'b0, 2'd0, 1'b1, 2'(k), 32'h0, 32'h0, mem, 32'hFFFF_FFFF);
            chk("R2 sbyte", rsp_ld0, {{24{b[7]}}, b});
            chk("R4 ld1 zero narrow", rsp_ld1, 32'h0);
        end
    endtask

    task automatic t_half_loads();
        issue(1'b0, 2'd1, 1'b0, 2'd0, 0, 0, 32'h1234_9ABC, 0);
        chk("R3 uhalf lo", rsp_ld0, 32'h0000_9ABC);
        issue(1'b0, 2'd1, 1'b1, 2'd0, 0, 0, 32'h1234_9ABC, 0);
        chk("R3 shalf lo neg", rsp_ld0, 32'hFFFF_9ABC);
        issue(1'b0, 2'd1, 1'b1, 2'd2, 0, 0, 32'h1234_9ABC, 0);
        chk("R3 shalf hi pos", rsp_ld0, 32'h0000_1234);
        issue(1'b0, 2'd1, 1'b0, 2'd2, 0, 0, 32'hF00D_0001, 0);
        chk("R3 uhalf hi", rsp_ld0, 32'h0000_F00D);
    endtask

    task automatic t_word_dbl_loads();
        issue(1'b0, 2'd2, 1'b1, 2'd0, 0, 0, 32'h8000_00FF, 32'h5555_5555);
        chk("R4 word signed ignored", rsp_ld0, 32'h8000_00FF);
        chk("R4 word ld1", rsp_ld1, 32'h0);
        issue(1'b0, 2'd3, 1'b1, 2'd0, 0, 0, 32'hDEAD_BEEF, 32'h0123_4567);
        chk("R5 dbl low", rsp_ld0, 32'hDEAD_BEEF);
        chk("R5 dbl high", rsp_ld1, 32'h0123_4567);
        chk("R12 dbl load no be", {24'b0, rsp_be_hi, rsp_be_lo}, 32'h0);
    endtask

    task automatic t_stores();
        for (int k = 0; k < 4; k++) begin
            issue(1'b1, 2'd0, 1'(k & 1), 2'(k), 32'hFFEE_DDA5, 32'h0, 32'h0, 32'h0);
            chk("R6 byte data", rsp_wdata_lo, 32'hA5A5_A5A5);
            chk("R6 byte be", {28'b0, rsp_be_lo}, 32'(1 << k));
            chk("R8 byte be_hi", {28'b0, rsp_be_hi}, 32'h0);
        end
        issue(1'b1, 2'd1, 1'b1, 2'd0, 32'h7777_C001, 0, 0, 0);
        chk("R7 half data", rsp_wdata_lo, 32'hC001_C001);
        chk("R7 half be lo", {28'b0, rsp_be_lo}, 32'h3);
        issue(1'b1, 2'd1, 1'b0, 2'd2, 32'h7777_C001, 0, 0, 0);
        chk("R7 half be hi", {28'b0, rsp_be_lo}, 32'hC);
        issue(1'b1, 2'd2, 1'b1, 2'd0, 32'h89AB_CDEF, 32'h1111_1111, 0, 0);
        chk("R8 word data", rsp_wdata_lo, 32'h89AB_CDEF);
        chk("R8 word be", {24'b0, rsp_be_hi, rsp_be_lo}, 32'h0F);
        chk("R8 word hi data", rsp_wdata_hi, 32'h0);
        issue(1'b1, 2'd3, 1'b0, 2'd0, 32'hAAAA_0000, 32'h0000_BBBB, 0, 0);
        chk("R8 dbl lo", rsp_wdata_lo, 32'hAAAA_0000);
        chk("R8 dbl hi", rsp_wdata_hi, 32'h0000_BBBB);
        chk("R8 dbl be", {24'b0, rsp_be_hi, rsp_be_lo}, 32'hFF);
        chk("R9 aligned dbl no fault", {31'b0, rsp_fault}, 32'h0);
    endtask

    task automatic t_faults();
        for (int sz = 1; sz < 4; sz++) begin
            for (int k = 1; k < 4; k++) begin
                logic exp_f = (sz == 1) ? 1'(k & 1) : 1'b1;
                issue(1'b1, 2'(sz), 1'b0, 2'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
                chk("R9 store fault", {31'b0, rsp_fault}, {31'b0, exp_f});
                if (exp_f) begin
                    chk("R10 fault be", {24'b0, rsp_be_hi, rsp_be_lo}, 32'h0);
                    chk("R10 fault wdata", rsp_wdata_lo | rsp_wdata_hi, 32'h0);
                end
                issue(1'b0, 2'(sz), 1'b1, 2'(k), 0, 0, 32'h8888_8888, 32'h9999_9999);
                chk("R9 load fault", {31'b0, rsp_fault}, {31'b0, exp_f});
                if (exp_f) chk("R10 fault ld", rsp_ld0 | rsp_ld1, 32'h0);
            end
        end
        issue(1'b1, 2'd0, 1'b0, 2'd3, 32'h42, 0, 0, 0);
        chk("R9 byte odd no fault", {31'b0, rsp_fault}, 32'h0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        req_store = 1'b1; req_size = 2'd2; req_byte_ofs = 2'd0; req_reg0 = 32'hFFFF_FFFF;
        @(posedge clk);
        #2;
        chk("R11 idle valid", {31'b0, rsp_valid}, 32'h0);
        chk("R12 idle be", {24'b0, rsp_be_hi, rsp_be_lo}, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
        req_signed = 1'b0; req_byte_ofs = 2'd0; req_reg0 = '0; req_reg1 = '0;
        mem_rd_lo = '0; mem_rd_hi = '0;
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_byte_loads();
        t_half_loads();
        t_word_dbl_loads();
        t_stores();
        t_faults();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule